// File: doc/BRIEF.md
# Block Write Protection Controller

This block decides whether a write arriving from a serial memory's bus controller may go ahead. It keeps an 8-bit protection register that sits at the topmost address of the byte array, and it samples an external write-protect pin through a short synchroniser. The bus controller first marks the start of a write with a strobe that captures the target address. It then raises a one-cycle request carrying the data byte. One cycle later the block answers with a one-cycle grant or a one-cycle deny. A denied write is dropped and must start no write cycle.

Three mechanisms combine. A software enable latch must be set before any array byte can be written. A two-bit span code shields the top quarter, the top half or the whole array. A lock enable bit, while the pin is high, freezes the protection register itself. With the lock bit clear, a board can hold the pin high and still program every byte in place, then set the lock bit last. The register is modelled as a plain register with a reset value; a parameter supplies that value for tests, and the enable latch always comes up clear.

Top module: `wpc_guard`

## Requirements
- R1: After reset the protection register reads INIT_VAL with only bits 1, 2, 3 and 7 kept and bit 1 forced to 0. Grant and deny are both low.
- R2: Each cycle with wr_req_i high is followed, in the next cycle, by exactly one of grant_o or deny_o high for one cycle. Neither output is high in any other cycle.
- R3: While the enable latch (register bit 1) is 0, every write to an array address (any address other than all ones) is denied.
- R4: The span code in register bits 3:2 denies array writes as follows. 00 denies none. 01 denies addresses whose two top bits are 11 (1800h to 1FFEh at 13 bits). 10 denies addresses whose top bit is 1. 11 denies every array address. This holds whatever the lock bit and the pin are.
- R5: When register bit 7 (lock) is 1 and the synchronised pin is high, a write to the all-ones address is denied and the register keeps its value.
- R6: A write to the all-ones address is granted when the lock bit is 0 or the pin is low, whatever the enable latch holds. With the pin high and the lock bit clear, array writes follow only R3 and R4.
- R7: A granted write to the all-ones address loads the data byte into the register, keeping bits 1, 3:2 and 7 and reading every other bit as 0. The register changes at no other time.
- R8: The decision uses the address captured on the last wr_start_i pulse before the request. wr_addr_i in later cycles has no effect.
- R9: A change on wp_pin_i governs every request issued SYNC_STAGES+1 or more cycles after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin_i | input | 1 | External write-protect pin, asynchronous |
| wr_start_i | input | 1 | Start-of-write strobe; captures wr_addr_i |
| wr_addr_i | input | ADDR_W | Target byte address |
| wr_req_i | input | 1 | One-cycle write request carrying wr_data_i |
| wr_data_i | input | DATA_W | Data byte for the request |
| grant_o | output | 1 | One-cycle pulse: the write may proceed |
| deny_o | output | 1 | One-cycle pulse: the write is discarded |
| prot_q_o | output | DATA_W | Current protection register contents |

## Verification
Directed writes land on both sides of each span boundary (0FFFh/1000h, 17FFh/1800h, 0000h and 1FFEh). They run under every span code, so a wrong or off-by-one region compare shows up. The register address is hit in all four lock-bit and pin combinations, separating a frozen register from a writable one and exposing a lock that ignores the pin. Seeded random traffic mixes register loads, array writes biased toward boundaries, pin toggles and address changes after the start strobe, and checks every answer against a bench model of the register.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   localparam int WEL_BIT  = 1;
   localparam int SPAN_LO  = 2;
   localparam int SPAN_HI  = 3;
   localparam int LOCK_BIT = 7;
   localparam logic [7:0] FIELD_MASK = 8'h8E;

   typedef enum logic [1:0] {
      SPAN_NONE    = 2'b00,
      SPAN_QUARTER = 2'b01,
      SPAN_HALF    = 2'b10,
      SPAN_ALL     = 2'b11
   } span_e;

   typedef struct packed {
      logic  lock;
      span_e span;
      logic  wel;
   } prot_fields_t;

   function automatic prot_fields_t unpack_fields(input logic [7:0] r);
      prot_fields_t f;
      f.lock = r[LOCK_BIT];
      f.span = span_e'(r[SPAN_HI:SPAN_LO]);
      f.wel  = r[WEL_BIT];
      return f;
   endfunction
endpackage

// File: rtl/wpc_pin_sync.sv
module wpc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic pin_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= pin_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], pin_i};
         end
      end
   endgenerate

   assign pin_o = chain_q[STAGES-1];
endmodule

// File: rtl/wpc_span_decode.sv
module wpc_span_decode
   import wpc_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  span_e             span_i,
   output logic              hit_o
);
   logic top_half;
   logic top_quarter;

   assign top_half    = addr_i[ADDR_W-1];
   assign top_quarter = &addr_i[ADDR_W-1:ADDR_W-2];

   always_comb begin
      unique case (span_i)
         SPAN_NONE:    hit_o = 1'b0;
         SPAN_QUARTER: hit_o = top_quarter;
         SPAN_HALF:    hit_o = top_half;
         default:      hit_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/wpc_prot_reg.sv
module wpc_prot_reg
   import wpc_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  INIT_VAL = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   localparam logic [DATA_W-1:0] KEEP = DATA_W'(FIELD_MASK);
   localparam logic [DATA_W-1:0] RST_VAL =
      DATA_W'(INIT_VAL & FIELD_MASK & ~(8'h01 << WEL_BIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RST_VAL;
      else if (we_i) q_o <= d_i & KEEP;
   end

   // R7: reserved positions never hold a one
   p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o & ~KEEP) == '0);
endmodule

// File: rtl/wpc_guard.sv
module wpc_guard
   import wpc_pkg::*;
#(
   parameter int         ADDR_W      = 13,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] INIT_VAL    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_pin_i,
   input  logic              wr_start_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              wr_req_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              grant_o,
   output logic              deny_o,
   output logic [DATA_W-1:0] prot_q_o
);
   localparam logic [ADDR_W-1:0] REG_ADDR = '1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("wpc_guard: ADDR_W must be at least 2");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("wpc_guard: DATA_W must be at least 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("wpc_guard: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic              wp_s;
   logic              span_hit;
   logic              to_reg;
   logic              allow;
   logic              reg_we;
   prot_fields_t      fld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr_q <= '0;
      else if (wr_start_i) addr_q <= wr_addr_i;
   end

   wpc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (wp_pin_i),
      .pin_o (wp_s)
   );

   assign fld    = unpack_fields(prot_q_o[7:0]);
   assign to_reg = (addr_q == REG_ADDR);

   wpc_span_decode #(.ADDR_W(ADDR_W)) u_span (
      .addr_i (addr_q),
      .span_i (fld.span),
      .hit_o  (span_hit)
   );

   always_comb begin
      if (to_reg) allow = !(fld.lock && wp_s);
      else        allow = fld.wel && !span_hit;
   end

   assign reg_we = wr_req_i && allow && to_reg;

   wpc_prot_reg #(.DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (reg_we),
      .d_i   (wr_data_i),
      .q_o   (prot_q_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o <= 1'b0;
         deny_o  <= 1'b0;
      end else begin
         grant_o <= wr_req_i && allow;
         deny_o  <= wr_req_i && !allow;
      end
   end

   // R2: a request gets exactly one answer next cycle
   p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_i |=> (grant_o ^ deny_o));
   // R2: no answer without a request
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o || deny_o) |-> $past(wr_req_i));
   // R3: latch clear blocks array writes
   p_wel_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && !to_reg && !fld.wel) |=> deny_o);
   // R4: a shielded array address is refused
   p_span_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && !to_reg && span_hit) |=> deny_o);
   // R5: locked register refuses and holds
   p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && to_reg && fld.lock && wp_s) |=> (deny_o && $stable(prot_q_o)));
   // R7: the register moves only on a granted write
   p_reg_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_q_o) |-> grant_o);
endmodule

// File: tb/wpc_guard_bench.sv
module wpc_guard_bench;
   localparam int ADDR_W = 13;
   localparam int DATA_W = 8;
   localparam int SYNC   = 2;
   localparam logic [7:0] INIT = 8'hFF;
   localparam logic [ADDR_W-1:0] TOP = 13'h1FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wp = 1'b0;
   logic start = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic req = 1'b0;
   logic [DATA_W-1:0] data = '0;
   logic grant, deny;
   logic [DATA_W-1:0] prot_q;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] m_reg;

   always #2.5 clk = ~clk;

   wpc_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC), .INIT_VAL(INIT))
   u_wpc_guard (
      .clk(clk), .rst_n(rst_n), .wp_pin_i(wp), .wr_start_i(start),
      .wr_addr_i(addr), .wr_req_i(req), .wr_data_i(data),
      .grant_o(grant), .deny_o(deny), .prot_q_o(prot_q)
   );

   function automatic bit want_grant(input logic [ADDR_W-1:0] a,
                                     input logic [7:0] r, input logic pin);
      if (a == TOP) return !(r[7] && pin);
      if (!r[1]) return 1'b0;
      case (r[3:2])
         2'b00:   return 1'b1;
         2'b01:   return a < 13'h1800;
         2'b10:   return a < 13'h1000;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
      end
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk) wp = v;
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                           input string req_tag);
      bit ok;
      @(negedge clk);
      start = 1'b1; addr = a;
      @(negedge clk);
      start = 1'b0;
      addr = ADDR_W'($urandom);   // R8: later address must not matter
      req = 1'b1; data = d;
      ok = want_grant(a, m_reg, wp);
      @(negedge clk);
      req = 1'b0;
      check(req_tag, {31'd0, grant}, {31'd0, ok});
      check(req_tag, {31'd0, deny}, {31'd0, !ok});
      if (ok && a == TOP) m_reg = d & 8'h8E;
      check({req_tag, "/R7 reg"}, {24'd0, prot_q}, {24'd0, m_reg});
      @(negedge clk);
      check("R2 pulse ends", {30'd0, grant, deny}, 32'd0);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_reg = INIT & 8'h8E & 8'hFD;
      @(negedge clk);
      check("R1 reset reg", {24'd0, prot_q}, {24'd0, m_reg});
      check("R1 reset outs", {30'd0, grant, deny}, 32'd0);

      // R3: latch clear refuses array writes
      do_write(13'h0000, 8'h00, "R3 wel clear low");
      do_write(13'h0ABC, 8'h00, "R3 wel clear mid");
      // R6: register writable with latch clear
      do_write(TOP, 8'hF3, "R6 reg wel clear");        // -> 0x82, wel=1, span 00
      do_write(13'h1FFE, 8'h11, "R4 span none top");
      for (int c = 1; c < 4; c++) begin
         do_write(TOP, 8'h02 | 8'(c << 2), "R7 set span");
         do_write(13'h0FFF, 8'h5A, "R4 below half");
         do_write(13'h1000, 8'h5A, "R4 half edge");
         do_write(13'h17FF, 8'h5A, "R4 below quarter");
         do_write(13'h1800, 8'h5A, "R4 quarter edge");
         do_write(13'h0000, 8'h5A, "R4 bottom");
      end
      // R5/R6 lock combinations
      do_write(TOP, 8'h82, "R6 set lock");               // lock=1 wel=1 span 00
      set_pin(1'b1);
      do_write(TOP, 8'h0E, "R5 locked reg");
      do_write(13'h1234, 8'h77, "R6 array with lock+pin");
      set_pin(1'b0);
      do_write(TOP, 8'h86, "R9 pin low unlocks");         // span 01
      set_pin(1'b1);
      do_write(13'h1800, 8'h01, "R4 span under lock");
      do_write(TOP, 8'h02, "R5 locked again");
      set_pin(1'b0);
      do_write(TOP, 8'h02, "R6 clear lock");
      set_pin(1'b1);
      do_write(TOP, 8'h06, "R6 pin high no lock");
      do_write(13'h1FFE, 8'h01, "R6 in place span");

      for (int i = 0; i < 400; i++) begin
         logic [ADDR_W-1:0] a;
         int k = $urandom_range(0, 9);
         if (k < 3)      a = TOP;
         else if (k < 6) a = ADDR_W'(({$urandom_range(0,3)} << 11) + $urandom_range(0,1) - 1);
         else            a = ADDR_W'($urandom);
         if ($urandom_range(0, 9) == 0) set_pin(1'($urandom));
         do_write(a, 8'($urandom), "R8 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule